// File: doc/BRIEF.md
# Byte-Serial Peripheral Transceiver (Master or Slave)

This block moves one byte at a time over a four-wire style serial link, always full duplex: every byte shifted out comes with one byte shifted in. A host reaches it through a small register port with four addresses. The host sets the role (clock master or clock follower), the bit order, the clock edge used to launch data, the divider for the master clock and two interrupt enables. To send, it waits until the transmit buffer shows empty and writes one byte.

As master, the block generates exactly eight clock pulses from a programmable divider of the system clock. The serial clock rests low between bytes. As slave, it follows an external clock after passing it through a two-stage synchronizer. In both roles, a completed byte sets a completion flag and stores the received byte for the host. This holds even when the host only wants to receive and writes a dummy byte to start the exchange. A new byte that arrives before the previous one was read raises an overrun flag, and the overrun can also raise an interrupt.

Top module: `spi_xcvr`

## Requirements
- R1: After reset, every register reads 0, `sclk_o` is low and both interrupt outputs are low.
- R2: Register map (`reg_addr`). Address 0 is control: bit0 selects master, bit1 selects LSB first, bit2 selects launch on the rising edge, bit3 enables the transmit-empty interrupt, bit4 enables the overrun interrupt. Address 1 is the divider. Address 2 is status: bit0 transmit buffer full, bit1 transfer complete, bit2 receive full, bit3 overrun, bit4 busy. Address 3 is data: a write fills the transmit buffer and a read returns the received byte. Control and divider read back what was written.
- R3: A data write while the transmit buffer is full is dropped. The buffered byte is kept and is the next byte sent.
- R4: In master mode, a buffered byte starts a transfer when the block is idle. The transfer has exactly 8 high pulses on `sclk_o`, each clock phase lasting divider+1 system clocks, and `sclk_o` is low before and after.
- R5: With control bit2 = 0, the first bit is on `sdo` before the first rising edge, later bits change on falling edges, and `sdi` is sampled on rising edges. With bit2 = 1, bits change on rising edges (the first bit stays put through the first rising edge) and `sdi` is sampled on falling edges.
- R6: Bits travel most significant first. With control bit1 = 1 they travel least significant first, in both directions.
- R7: After the eighth sampled bit, the complete flag and the receive-full flag are set and the data register returns the received byte. This also applies when a dummy byte was sent. Writing 1 to status bit1 clears the complete flag.
- R8: Reading the data register clears the receive-full flag.
- R9: If a byte completes while receive-full is still set, the overrun flag is set and the new byte replaces the old one. Writing 1 to status bit3 clears the overrun flag.
- R10: `irq_txe` is high exactly when the transmit buffer is empty and control bit3 is set. `irq_ovr` is high exactly when the overrun flag and control bit4 are both set.
- R11: In slave mode, the block shifts on `sclk_i`, whose high and low phases each last at least 4 system clocks. A buffered byte moves into the shifter only while no byte is in progress. A byte that completes with the buffer empty is followed by the dummy byte 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| sclk_o | output | 1 | Serial clock driven in master mode |
| sclk_i | input | 1 | Serial clock received in slave mode |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| irq_txe | output | 1 | Transmit buffer empty interrupt |
| irq_ovr | output | 1 | Receive overrun interrupt |

## Verification
The bench sweeps both launch edges, both bit orders and three divider values in master mode. A model on the far side of the link records each bit that leaves the block and supplies its own byte. A design that sampled on the launch edge, or shifted at the first rising edge in the rising-launch mode, would return both bytes off by one bit. The bench counts the clock pulses and the time `sclk_o` spends high, which catches a ninth pulse, a divider off by one, or a clock left high at the end. In slave mode it writes a second byte partway through a byte and then a third, and checks that the second one comes out next and that the dummy byte follows once the buffer runs dry; a design that loaded mid-byte or accepted the third write fails there. Back-to-back unread bytes check that the overrun flag is set, that the newer byte wins, and that clearing the flag also drops the interrupt.

// File: rtl/spi_xcvr_pkg.sv
package spi_xcvr_pkg;

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_DIV  = 2'd1,
        ADDR_STAT = 2'd2,
        ADDR_DATA = 2'd3
    } reg_addr_e;

    // bit0 master ... bit4 ovr_ie
    typedef struct packed {
        logic ovr_ie;
        logic txe_ie;
        logic launch_rise;
        logic lsb_first;
        logic master;
    } ctrl_t;

    localparam int unsigned CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/spi_clkgen.sv
module spi_clkgen #(
    parameter int unsigned DIV_W  = 8,
    parameter int unsigned BYTE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             sclk,
    output logic             rise_p,
    output logic             fall_p,
    output logic             last_p
);
    localparam int unsigned TOGS  = 2 * BYTE_W;
    localparam int unsigned TOG_W = $clog2(TOGS);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             sclk;
        logic [TOG_W-1:0] tog;
    } cg_t;

    cg_t st_q, st_d;

    always_comb begin
        st_d   = st_q;
        rise_p = 1'b0;
        fall_p = 1'b0;
        last_p = 1'b0;
        if (!run) begin
            st_d.cnt  = '0;
            st_d.sclk = 1'b0;
            st_d.tog  = '0;
        end else if (st_q.cnt == div) begin
            st_d.cnt  = '0;
            st_d.sclk = ~st_q.sclk;
            st_d.tog  = st_q.tog + 1'b1;
            rise_p    = ~st_q.sclk;
            fall_p    = st_q.sclk;
            last_p    = (st_q.tog == TOG_W'(TOGS - 1));
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sclk = st_q.sclk;

endmodule

// File: rtl/spi_slave_sync.sv
module spi_slave_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic sdi,
    output logic rise_p,
    output logic fall_p,
    output logic sdi_s
);
    typedef struct packed {
        logic [1:0] ck;
        logic       ck_prev;
        logic [1:0] dt;
    } sy_t;

    sy_t st_q, st_d;

    always_comb begin
        st_d         = st_q;
        st_d.ck      = {st_q.ck[0], sclk_i};
        st_d.ck_prev = st_q.ck[1];
        st_d.dt      = {st_q.dt[0], sdi};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_p = st_q.ck[1] & ~st_q.ck_prev;
    assign fall_p = ~st_q.ck[1] & st_q.ck_prev;
    assign sdi_s  = st_q.dt[1];

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_byte,
    input  logic              lsb_first,
    input  logic              sample_p,
    input  logic              shift_p,
    input  logic              sdi,
    output logic              sdo,
    output logic              mid_byte,
    output logic              done_p,
    output logic [BYTE_W-1:0] rx_byte
);
    localparam int unsigned CNT_W = $clog2(BYTE_W);

    typedef struct packed {
        logic [BYTE_W-1:0] tx;
        logic [BYTE_W-1:0] rx;
        logic [CNT_W-1:0]  cnt;
        logic              smp;
    } en_t;

    en_t st_q, st_d;
    logic [BYTE_W-1:0] rx_next;

    always_comb begin
        rx_next = lsb_first ? {sdi, st_q.rx[BYTE_W-1:1]}
                            : {st_q.rx[BYTE_W-2:0], sdi};
        st_d    = st_q;
        done_p  = 1'b0;
        if (sample_p) begin
            st_d.rx  = rx_next;
            st_d.smp = 1'b1;
            if (st_q.cnt == CNT_W'(BYTE_W - 1)) begin
                done_p   = 1'b1;
                st_d.cnt = '0;
                st_d.smp = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else if (shift_p && st_q.smp) begin
            st_d.tx  = lsb_first ? (st_q.tx >> 1) : (st_q.tx << 1);
            st_d.smp = 1'b0;
        end
        if (load) begin
            st_d.tx  = load_byte;
            st_d.cnt = '0;
            st_d.smp = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sdo      = lsb_first ? st_q.tx[0] : st_q.tx[BYTE_W-1];
    assign mid_byte = (st_q.cnt != '0) || st_q.smp;
    assign rx_byte  = rx_next;

endmodule

// File: rtl/spi_xcvr.sv
module spi_xcvr
    import spi_xcvr_pkg::*;
#(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic              sclk_o,
    input  logic              sclk_i,
    output logic              sdo,
    input  logic              sdi,
    output logic              irq_txe,
    output logic              irq_ovr
);
    localparam int unsigned REG_W = BYTE_W;

    typedef struct packed {
        ctrl_t             ctrl;
        logic [DIV_W-1:0]  div;
        logic [BYTE_W-1:0] tx_buf;
        logic              tx_full;
        logic              busy;
        logic              done;
        logic [BYTE_W-1:0] rx_data;
        logic              rx_full;
        logic              ovr;
    } top_t;

    top_t st_q, st_d;

    logic              cg_rise, cg_fall, cg_last, cg_sclk;
    logic              sy_rise, sy_fall, sy_sdi;
    logic              rise_sel, fall_sel, sample_p, shift_p, eng_sdi;
    logic              eng_load, eng_mid, eng_done;
    logic [BYTE_W-1:0] eng_byte, eng_rx;
    reg_addr_e         addr;

    assign addr = reg_addr_e'(reg_addr);

    spi_clkgen #(.DIV_W(DIV_W), .BYTE_W(BYTE_W)) clkgen_i (
        .clk(clk), .rst_n(rst_n), .run(st_q.busy), .div(st_q.div),
        .sclk(cg_sclk), .rise_p(cg_rise), .fall_p(cg_fall), .last_p(cg_last)
    );

    spi_slave_sync sync_i (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .sdi(sdi),
        .rise_p(sy_rise), .fall_p(sy_fall), .sdi_s(sy_sdi)
    );

    assign rise_sel = st_q.ctrl.master ? cg_rise : sy_rise;
    assign fall_sel = st_q.ctrl.master ? cg_fall : sy_fall;
    assign sample_p = st_q.ctrl.launch_rise ? fall_sel : rise_sel;
    assign shift_p  = st_q.ctrl.launch_rise ? rise_sel : fall_sel;
    assign eng_sdi  = st_q.ctrl.master ? sdi : sy_sdi;

    spi_shift_engine #(.BYTE_W(BYTE_W)) engine_i (
        .clk(clk), .rst_n(rst_n), .load(eng_load), .load_byte(eng_byte),
        .lsb_first(st_q.ctrl.lsb_first), .sample_p(sample_p), .shift_p(shift_p),
        .sdi(eng_sdi), .sdo(sdo), .mid_byte(eng_mid), .done_p(eng_done),
        .rx_byte(eng_rx)
    );

    always_comb begin
        st_d     = st_q;
        eng_load = 1'b0;
        eng_byte = st_q.tx_buf;

        if (reg_wr) begin
            unique case (addr)
                ADDR_CTRL: st_d.ctrl = ctrl_t'(reg_wdata[CTRL_W-1:0]);
                ADDR_DIV:  st_d.div  = reg_wdata[DIV_W-1:0];
                ADDR_STAT: begin
                    if (reg_wdata[1]) st_d.done = 1'b0;
                    if (reg_wdata[3]) st_d.ovr  = 1'b0;
                end
                ADDR_DATA: begin
                    if (!st_q.tx_full) begin
                        st_d.tx_buf  = reg_wdata;
                        st_d.tx_full = 1'b1;
                    end
                end
                default: ;
            endcase
        end
        if (reg_rd && addr == ADDR_DATA) st_d.rx_full = 1'b0;

        if (st_q.ctrl.master) begin
            if (!st_q.busy && st_q.tx_full) begin
                eng_load     = 1'b1;
                st_d.tx_full = 1'b0;
                st_d.busy    = 1'b1;
            end
            if (cg_last) st_d.busy = 1'b0;
        end else begin
            st_d.busy = 1'b0;
            if (eng_done) begin
                eng_load = 1'b1;
                if (st_q.tx_full) st_d.tx_full = 1'b0;
                else              eng_byte     = '0;
            end else if (st_q.tx_full && !eng_mid) begin
                eng_load     = 1'b1;
                st_d.tx_full = 1'b0;
            end
        end

        if (eng_done) begin
            st_d.rx_data = eng_rx;
            st_d.done    = 1'b1;
            st_d.rx_full = 1'b1;
            if (st_q.rx_full && !(reg_rd && addr == ADDR_DATA)) st_d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (addr)
            ADDR_CTRL: reg_rdata = REG_W'(st_q.ctrl);
            ADDR_DIV:  reg_rdata = REG_W'(st_q.div);
            ADDR_STAT: reg_rdata = REG_W'({st_q.busy | eng_mid, st_q.ovr,
                                           st_q.rx_full, st_q.done, st_q.tx_full});
            ADDR_DATA: reg_rdata = st_q.rx_data;
            default:   reg_rdata = '0;
        endcase
    end

    assign sclk_o  = cg_sclk;
    assign irq_txe = ~st_q.tx_full & st_q.ctrl.txe_ie;
    assign irq_ovr = st_q.ovr & st_q.ctrl.ovr_ie;

endmodule

// File: rtl/spi_xcvr_chk.sv
module spi_xcvr_chk #(
    parameter int unsigned BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        reg_addr,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic              sclk_o,
    input logic              busy,
    input logic              tx_full,
    input logic [BYTE_W-1:0] tx_buf,
    input logic              rx_full,
    input logic              ovr,
    input logic              done_flag,
    input logic              eng_done,
    input logic              eng_load,
    input logic              eng_mid
);
    // R3
    full_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_addr == 2'd3 && tx_full |=> $stable(tx_buf));

    // R4
    idle_clock_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !sclk_o);

    // R4
    end_clock_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !sclk_o);

    // R7
    done_sets_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> done_flag && rx_full);

    // R9
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done && rx_full && !(reg_rd && reg_addr == 2'd3) |=> ovr);

    // R11
    load_between_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_load |-> (!eng_mid || eng_done));

endmodule

bind spi_xcvr spi_xcvr_chk #(.BYTE_W(BYTE_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .sclk_o(sclk_o), .busy(st_q.busy), .tx_full(st_q.tx_full),
    .tx_buf(st_q.tx_buf), .rx_full(st_q.rx_full), .ovr(st_q.ovr),
    .done_flag(st_q.done), .eng_done(eng_done), .eng_load(eng_load),
    .eng_mid(eng_mid)
);

// File: tb/spi_xcvr_tb.sv
module spi_xcvr_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic       sclk_o, sdo, irq_txe, irq_ovr;
    logic       sclk_i = 1'b0;
    logic       sdi, bm_sdi, sl_sdi = 1'b0;
    logic       use_bm = 1'b0;

    int n_tests = 0, n_fail = 0, cyc = 0;

    always #10 clk = ~clk;

    spi_xcvr dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sclk_o(sclk_o), .sclk_i(sclk_i), .sdo(sdo), .sdi(sdi),
        .irq_txe(irq_txe), .irq_ovr(irq_ovr)
    );

    // far-end model for master transfers
    logic       bm_on = 1'b0, bm_m = 1'b0, bm_o = 1'b0, bm_flag = 1'b0;
    logic [2:0] bm_k = '0;
    logic [7:0] bm_tx = '0, bm_cap = '0;
    int         n_rise = 0, n_hi = 0;

    assign bm_sdi = bm_tx[bm_o ? bm_k : 3'd7 - bm_k];
    assign sdi    = use_bm ? bm_sdi : sl_sdi;

    always @(sclk_o) begin
        if (bm_on) begin
            if ((bm_m == 1'b0) == (sclk_o == 1'b1)) begin
                bm_cap[bm_o ? bm_k : 3'd7 - bm_k] = sdo;
                bm_flag = 1'b1;
            end else if (bm_flag) begin
                bm_k    = bm_k + 3'd1;
                bm_flag = 1'b0;
            end
        end
    end
    always @(posedge sclk_o) if (bm_on) n_rise++;
    always @(negedge clk) if (bm_on && sclk_o) n_hi++;

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_rd = 1'b1;
        #2 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int i = 0; i < 2000; i++) begin
            rd(2'd2, s);
            if (s[1] && !s[4]) break;
        end
    endtask

    // master transfer: dtx from block, stx from far end
    task automatic m_xfer(input logic [7:0] dtx, input logic [7:0] stx, input logic m,
                          input logic o, input logic [7:0] d, input logic [7:0] ie,
                          input bit read_it);
        logic [7:0] r;
        bm_tx = stx; bm_m = m; bm_o = o; bm_k = '0; bm_flag = 1'b0; bm_cap = '0;
        n_rise = 0; n_hi = 0; use_bm = 1'b1; bm_on = 1'b1;
        wr(2'd1, d);
        wr(2'd0, ie | {5'd0, m, o, 1'b1});
        wr(2'd3, dtx);
        wait_idle();
        bm_on = 1'b0;
        chk("R5/R6 bits leaving block", int'(bm_cap), int'(dtx));
        chk("R4 pulse count", n_rise, 8);
        chk("R4 high time", n_hi, 8 * (int'(d) + 1));
        chk("R4 clock idles low", int'(sclk_o), 0);
        if (read_it) begin
            rd(2'd2, r);
            chk("R7 complete and receive-full", int'(r[2:1]), 3);
            rd(2'd3, r);
            chk("R7 received byte", int'(r), int'(stx));
            rd(2'd2, r);
            chk("R8 receive-full cleared", int'(r[2]), 0);
            wr(2'd2, 8'h02);
            rd(2'd2, r);
            chk("R7 complete cleared", int'(r[1]), 0);
        end
    endtask

    task automatic s_bit(input logic b, output logic s);
        sl_sdi = b;
        repeat (4) @(negedge clk);
        s = sdo;
        sclk_i = 1'b1;
        repeat (4) @(negedge clk);
        sclk_i = 1'b0;
    endtask

    initial begin
        logic [7:0] r, cap, mo;
        logic       s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1
        rd(2'd0, r); chk("R1 control reset", int'(r), 0);
        rd(2'd1, r); chk("R1 divider reset", int'(r), 0);
        rd(2'd2, r); chk("R1 status reset", int'(r), 0);
        chk("R1 outputs reset", int'({sclk_o, irq_txe, irq_ovr}), 0);

        // R2
        wr(2'd0, 8'h1E); rd(2'd0, r); chk("R2 control readback", int'(r), 8'h1E);
        wr(2'd1, 8'h07); rd(2'd1, r); chk("R2 divider readback", int'(r), 8'h07);
        chk("R10 txe irq when empty and enabled", int'(irq_txe), 1);
        wr(2'd0, 8'h00);
        chk("R10 txe irq disabled", int'(irq_txe), 0);

        // master sweep: edge mode x bit order x divider
        for (int m = 0; m < 2; m++)
            for (int o = 0; o < 2; o++)
                for (int di = 0; di < 3; di++) begin
                    int idx = m * 6 + o * 3 + di;
                    logic [7:0] dv = (di == 2) ? 8'd3 : 8'(di);
                    logic [7:0] a  = 8'(8'h5A + 37 * idx);
                    logic [7:0] b  = 8'(8'hC3 ^ (29 * idx + 1));
                    m_xfer(a, b, m[0], o[0], dv, 8'h00, 1'b1);
                end

        // R7 receive-only with dummy byte
        m_xfer(8'h00, 8'h6D, 1'b0, 1'b0, 8'd1, 8'h00, 1'b1);

        // R9 overrun, R10 overrun interrupt
        m_xfer(8'h11, 8'hA1, 1'b0, 1'b0, 8'd0, 8'h10, 1'b0);
        rd(2'd2, r); chk("R9 no overrun after one byte", int'(r[3]), 0);
        chk("R10 ovr irq low", int'(irq_ovr), 0);
        m_xfer(8'h22, 8'hB2, 1'b1, 1'b1, 8'd0, 8'h10, 1'b0);
        rd(2'd2, r); chk("R9 overrun set", int'(r[3]), 1);
        chk("R10 ovr irq high", int'(irq_ovr), 1);
        rd(2'd3, r); chk("R9 newer byte kept", int'(r), 8'hB2);
        wr(2'd2, 8'h0A);
        rd(2'd2, r); chk("R9 overrun cleared", int'(r[3:1]), 0);
        chk("R10 ovr irq cleared", int'(irq_ovr), 0);

        // slave mode, falling launch, MSB first
        use_bm = 1'b0;
        wr(2'd0, 8'h08);
        wr(2'd3, 8'hA5);
        rd(2'd2, r); chk("R11 slave loads at once", int'(r[0]), 0);
        chk("R10 txe irq after load", int'(irq_txe), 1);
        mo = 8'h96; cap = '0;
        for (int i = 0; i < 8; i++) begin
            s_bit(mo[7 - i], s); cap[7 - i] = s;
            if (i == 2) begin
                wr(2'd3, 8'h3C);
                wr(2'd3, 8'hFF);
                rd(2'd2, r); chk("R3 buffer held full", int'(r[0]), 1);
                chk("R10 txe irq low when full", int'(irq_txe), 0);
            end
        end
        repeat (6) @(negedge clk);
        chk("R11 slave sent first byte", int'(cap), 8'hA5);
        rd(2'd3, r); chk("R11 slave received", int'(r), 8'h96);
        rd(2'd2, r); chk("R11 buffered byte moved in", int'(r[0]), 0);

        mo = 8'h0F; cap = '0;
        for (int i = 0; i < 8; i++) begin s_bit(mo[7 - i], s); cap[7 - i] = s; end
        repeat (6) @(negedge clk);
        chk("R3 dropped write not sent", int'(cap), 8'h3C);
        rd(2'd3, r); chk("R11 second byte received", int'(r), 8'h0F);

        mo = 8'hE7; cap = 8'hFF;
        for (int i = 0; i < 8; i++) begin s_bit(mo[7 - i], s); cap[7 - i] = s; end
        repeat (6) @(negedge clk);
        chk("R11 dummy byte when empty", int'(cap), 8'h00);
        rd(2'd3, r); chk("R11 third byte received", int'(r), 8'hE7);

        // slave, LSB first
        wr(2'd0, 8'h0A);
        wr(2'd3, 8'hB1);
        mo = 8'hC2; cap = '0;
        for (int i = 0; i < 8; i++) begin s_bit(mo[i], s); cap[i] = s; end
        repeat (6) @(negedge clk);
        chk("R6 slave LSB-first out", int'(cap), 8'hB1);
        rd(2'd3, r); chk("R6 slave LSB-first in", int'(r), 8'hC2);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule